// File: doc/BRIEF.md
# Command Packet Responder with Seconds Clock

This block sits behind a byte transport and answers controller command packets. A packet arrives as a stream of bytes, and its final byte is marked. The first byte gives the packet kind and the second gives the command code. Only controller-kind packets (kind value 1) are decoded. The block builds the matching reply in a small buffer and streams it out with a valid/ready handshake. Commands it does not know, and packets that are too short for their command, produce no reply.

The block keeps a 32-bit seconds counter. The counter counts from a 1904 epoch and advances once per one-second tick. Software can set the counter or read it, and both use big-endian byte order. An autopoll enable, switched by command, drives a periodic poll request at POLL_HZ. When poll data is handed in, it goes back to the host as a poll packet. Two commands raise a one-cycle shutdown or system-reset request. The request fires only after the host has accepted the last byte of the acknowledgement.

Top module: `cmd_responder`

## Requirements
- R1: After reset, rsp_valid_o, autopoll_o, poll_req_o, shutdown_req_o and reset_req_o are 0, and cmd_ready_o is 1.
- R2: Command 0x01 with at least one argument byte replies {0x01, arg}. It sets autopoll_o to 1 when arg is nonzero and to 0 when arg is zero.
- R3: Command 0x09 with four argument bytes loads the seconds counter, taking the first argument byte as bits 31:24. It replies {0x01, 0x00, 0x00}.
- R4: Command 0x03 replies with 7 bytes: {0x01, 0x00, 0x00, s[31:24], s[23:16], s[15:8], s[7:0]}. Here s is the counter value, and the counter increments by one on each cycle where tick_1s_i is high.
- R5: Commands 0x13, 0x14, 0x19 and 0x21 reply {0x01, 0x00} and change no state.
- R6: Command 0x0A and command 0x11 each reply {0x01, 0x00}. In the cycle after the last reply byte is accepted, 0x0A raises shutdown_req_o for one cycle and 0x11 raises reset_req_o for one cycle. Neither request is raised before that point.
- R7: A packet whose first byte is not 1, or whose command code is not listed in R2 to R6, produces no reply.
- R8: A packet shorter than its command needs produces no reply and changes no state. The needed lengths are 2 bytes in general, 3 bytes for 0x01 and 6 bytes for 0x09.
- R9: While autopoll_o is 1, poll_req_o pulses for one cycle every CLK_HZ/POLL_HZ cycles. While autopoll_o is 0, poll_req_o stays low.
- R10: A poll-data word accepted on poll_valid_i/poll_ready_o is sent as {0x00, 0x40, data bytes most significant first}.
- R11: A reply byte stays valid and unchanged until it is accepted. No command byte and no poll data is accepted while a reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command byte |
| cmd_last_i | input | 1 | Marks the final byte of a packet |
| cmd_ready_o | output | 1 | Command byte accepted when high with valid |
| rsp_valid_o | output | 1 | Reply byte valid |
| rsp_data_o | output | 8 | Reply byte |
| rsp_last_o | output | 1 | Marks the final reply byte |
| rsp_ready_i | input | 1 | Host accepts the reply byte |
| tick_1s_i | input | 1 | One-second tick |
| poll_req_o | output | 1 | Periodic poll request pulse |
| poll_valid_i | input | 1 | Poll data valid |
| poll_data_i | input | 8*POLL_BYTES | Poll data, first byte in the top bits |
| poll_ready_o | output | 1 | Poll data accepted when high with valid |
| autopoll_o | output | 1 | Autopoll enable state |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
The assertions assume that the host obeys the handshakes. It holds a command byte steady until that byte is taken, and it never raises rsp_ready_i in a way that depends on reply contents it has not yet seen. The assertions also assume that tick_1s_i and poll data come only between packets.

The bench drives every input at the falling edge and waits for ready before the rising edge. It sends one-second ticks and poll data only while no packet or reply is in flight. It lowers rsp_ready_i at random, so that the hold and stall properties are exercised while replies drain.

// File: rtl/cmd_responder_pkg.sv
package cmd_responder_pkg;
  localparam logic [7:0] KIND_PERIPH = 8'h00;
  localparam logic [7:0] KIND_CTRL   = 8'h01;
  localparam logic [7:0] POLL_TAG    = 8'h40;

  localparam logic [7:0] OP_AUTOPOLL = 8'h01;
  localparam logic [7:0] OP_GET_TIME = 8'h03;
  localparam logic [7:0] OP_SET_TIME = 8'h09;
  localparam logic [7:0] OP_PWR_DOWN = 8'h0A;
  localparam logic [7:0] OP_SYS_RST  = 8'h11;
  localparam logic [7:0] OP_ACK_A    = 8'h13;
  localparam logic [7:0] OP_ACK_B    = 8'h14;
  localparam logic [7:0] OP_ACK_C    = 8'h19;
  localparam logic [7:0] OP_ACK_D    = 8'h21;

  typedef enum logic [1:0] {ACT_NONE, ACT_OFF, ACT_RST} act_e;
endpackage

// File: rtl/pkt_capture.sv
module pkt_capture #(
  parameter int CAP = 6,
  localparam int LW = $clog2(CAP + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_i,
  input  logic [7:0]            data_i,
  input  logic                  last_i,
  output logic [CAP-1:0][7:0]   hdr_o,
  output logic [LW-1:0]         len_o,
  output logic                  done_o
);
  localparam logic [LW-1:0] SAT = LW'(CAP + 1);
  logic [LW-1:0] idx_q, idx_inc;

  assign idx_inc = (idx_q == SAT) ? SAT : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      len_o  <= '0;
      done_o <= 1'b0;
      hdr_o  <= '0;
    end else begin
      done_o <= acc_i && last_i;
      if (acc_i) begin
        if (idx_q < LW'(CAP)) hdr_o[idx_q[$clog2(CAP)-1:0]] <= data_i;
        idx_q <= last_i ? '0 : idx_inc;
        if (last_i) len_o <= idx_inc;
      end
    end
  end
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  output logic [W-1:0] sec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_o <= INIT;
    else if (set_i)  sec_o <= set_val_i;
    else if (tick_i) sec_o <= sec_o + 1'b1;
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int DIV = 2500000,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q   <= '0;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
  import cmd_responder_pkg::*;
#(
  parameter int          CLK_HZ     = 125000000,
  parameter int          POLL_HZ    = 50,
  parameter int          POLL_BYTES = 2,
  parameter logic [31:0] RTC_INIT   = 32'h0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [7:0]              cmd_data_i,
  input  logic                    cmd_last_i,
  output logic                    cmd_ready_o,
  output logic                    rsp_valid_o,
  output logic [7:0]              rsp_data_o,
  output logic                    rsp_last_o,
  input  logic                    rsp_ready_i,
  input  logic                    tick_1s_i,
  output logic                    poll_req_o,
  input  logic                    poll_valid_i,
  input  logic [8*POLL_BYTES-1:0] poll_data_i,
  output logic                    poll_ready_o,
  output logic                    autopoll_o,
  output logic                    shutdown_req_o,
  output logic                    reset_req_o
);
  localparam int CAP  = 6;
  localparam int LW   = $clog2(CAP + 2);
  localparam int RBUF = (POLL_BYTES + 2 > 7) ? POLL_BYTES + 2 : 7;
  localparam int RW   = $clog2(RBUF + 1);
  localparam int IW   = $clog2(RBUF);
  localparam int DIV  = CLK_HZ / POLL_HZ;

  logic [CAP-1:0][7:0] hdr;
  logic [LW-1:0]       cap_len;
  logic                cap_done;
  logic [31:0]         sec;

  logic [RBUF-1:0][7:0] rbuf_q, d_buf;
  logic [RW-1:0]        rlen_q, d_len;
  logic [IW-1:0]        ridx_q;
  act_e                 act_q, d_act;
  logic                 d_set, d_ap_wr, busy, rsp_hs;

  assign busy         = (rlen_q != '0);
  assign cmd_ready_o  = !busy && !cap_done;
  assign poll_ready_o = !busy && !cap_done;
  assign rsp_valid_o  = busy;
  assign rsp_data_o   = rbuf_q[ridx_q];
  assign rsp_last_o   = busy && (RW'(ridx_q) == rlen_q - 1'b1);
  assign rsp_hs       = rsp_valid_o && rsp_ready_i;

  pkt_capture #(.CAP(CAP)) u_cap (
    .clk_i, .rst_ni,
    .acc_i (cmd_valid_i && cmd_ready_o),
    .data_i(cmd_data_i),
    .last_i(cmd_last_i),
    .hdr_o (hdr),
    .len_o (cap_len),
    .done_o(cap_done)
  );

  sec_counter #(.W(32), .INIT(RTC_INIT)) u_sec (
    .clk_i, .rst_ni,
    .tick_i   (tick_1s_i),
    .set_i    (d_set),
    .set_val_i({hdr[2], hdr[3], hdr[4], hdr[5]}),
    .sec_o    (sec)
  );

  poll_timer #(.DIV(DIV)) u_poll (
    .clk_i, .rst_ni,
    .en_i   (autopoll_o),
    .pulse_o(poll_req_o)
  );

  always_comb begin
    d_len   = '0;
    d_buf   = '0;
    d_act   = ACT_NONE;
    d_set   = 1'b0;
    d_ap_wr = 1'b0;
    if (cap_done) begin
      if (hdr[0] == KIND_CTRL && cap_len >= LW'(2)) begin
        d_buf[0] = KIND_CTRL;
        case (hdr[1])
          OP_AUTOPOLL: if (cap_len >= LW'(3)) begin
            d_len    = RW'(2);
            d_buf[1] = hdr[2];
            d_ap_wr  = 1'b1;
          end
          OP_SET_TIME: if (cap_len >= LW'(6)) begin
            d_len = RW'(3);
            d_set = 1'b1;
          end
          OP_GET_TIME: begin
            d_len    = RW'(7);
            d_buf[3] = sec[31:24];
            d_buf[4] = sec[23:16];
            d_buf[5] = sec[15:8];
            d_buf[6] = sec[7:0];
          end
          OP_ACK_A, OP_ACK_B, OP_ACK_C, OP_ACK_D: d_len = RW'(2);
          OP_PWR_DOWN: begin d_len = RW'(2); d_act = ACT_OFF; end
          OP_SYS_RST:  begin d_len = RW'(2); d_act = ACT_RST; end
          default: d_len = '0;
        endcase
      end
    end else if (poll_valid_i && poll_ready_o) begin
      d_len    = RW'(POLL_BYTES + 2);
      d_buf[0] = KIND_PERIPH;
      d_buf[1] = POLL_TAG;
      for (int i = 0; i < POLL_BYTES; i++)
        d_buf[2+i] = poll_data_i[8*(POLL_BYTES-1-i) +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q         <= '0;
      rlen_q         <= '0;
      ridx_q         <= '0;
      act_q          <= ACT_NONE;
      autopoll_o     <= 1'b0;
      shutdown_req_o <= 1'b0;
      reset_req_o    <= 1'b0;
    end else begin
      shutdown_req_o <= 1'b0;
      reset_req_o    <= 1'b0;
      if (d_ap_wr) autopoll_o <= (hdr[2] != 8'h00);
      if (d_len != '0) begin
        rbuf_q <= d_buf;
        rlen_q <= d_len;
        ridx_q <= '0;
        act_q  <= d_act;
      end else if (rsp_hs) begin
        if (rsp_last_o) begin
          rlen_q         <= '0;
          shutdown_req_o <= (act_q == ACT_OFF);
          reset_req_o    <= (act_q == ACT_RST);
        end else begin
          ridx_q <= ridx_q + 1'b1;
        end
      end
    end
  end
endmodule

module cmd_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_ready_o,
  input logic       poll_ready_o,
  input logic       rsp_valid_o,
  input logic       rsp_ready_i,
  input logic [7:0] rsp_data_o,
  input logic       rsp_last_o,
  input logic       poll_req_o,
  input logic       autopoll_o,
  input logic       shutdown_req_o,
  input logic       reset_req_o
);
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o)); // R11
  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o && !poll_ready_o); // R11
  AST_OFF_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> $past(rsp_valid_o && rsp_ready_i && rsp_last_o)); // R6
  AST_RST_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(rsp_valid_o && rsp_ready_i && rsp_last_o)); // R6
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_req_o && reset_req_o)); // R6
  AST_POLL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_req_o |-> $past(autopoll_o)); // R9
  AST_POLL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_req_o |=> !poll_req_o); // R9
endmodule

bind cmd_responder cmd_responder_chk u_chk (
  .clk_i, .rst_ni, .cmd_ready_o, .poll_ready_o, .rsp_valid_o, .rsp_ready_i,
  .rsp_data_o, .rsp_last_o, .poll_req_o, .autopoll_o, .shutdown_req_o, .reset_req_o
);

// File: tb/cmd_responder_bench.sv
`timescale 1ns/1ps
module cmd_responder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_last = 0, rsp_ready = 0, tick = 0, poll_valid = 0;
  logic [7:0]  cmd_data = 0;
  logic [15:0] poll_data = 0;
  logic        cmd_ready, rsp_valid, rsp_last, poll_req, poll_ready, autopoll, shut_req, rst_req;
  logic [7:0]  rsp_data;

  cmd_responder #(.CLK_HZ(5000), .POLL_HZ(50), .POLL_BYTES(2), .RTC_INIT(32'h0)) u_cmd_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_last_i(cmd_last), .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last), .rsp_ready_i(rsp_ready),
    .tick_1s_i(tick), .poll_req_o(poll_req),
    .poll_valid_i(poll_valid), .poll_data_i(poll_data), .poll_ready_o(poll_ready),
    .autopoll_o(autopoll), .shutdown_req_o(shut_req), .reset_req_o(rst_req)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] pk[8];
  logic [7:0] rb[8];
  logic [7:0] eb[8];
  int rn, en;
  int early_pulse, hold_bad;
  logic [31:0] m_sec = 0;
  logic        m_ap = 0;

  task automatic chk(input bit ok, input string req, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_data = pk[i]; cmd_last = (i == n - 1);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 0; cmd_last = 0;
  endtask

  task automatic get_rsp(input bit rnd);
    logic [7:0] hd;
    bit held;
    rn = 0; early_pulse = 0; hold_bad = 0; held = 0; hd = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (shut_req || rst_req) early_pulse++;
      if (held && !(rsp_valid && rsp_data == hd)) hold_bad++;
      if (rsp_valid && cmd_ready) hold_bad++;
      rsp_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
      held = rsp_valid && !rsp_ready;
      hd = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (rn < 8) rb[rn] = rsp_data;
        rn++;
        if (rsp_last) begin
          @(posedge clk);
          @(negedge clk);
          rsp_ready = 0;
          return;
        end
      end
    end
    rsp_ready = 0;
  endtask

  function automatic void model(input int n);
    en = 0;
    if (n < 2 || pk[0] != 8'h01) return;
    eb[0] = 8'h01;
    case (pk[1])
      8'h01: if (n >= 3) begin en = 2; eb[1] = pk[2]; m_ap = (pk[2] != 0); end
      8'h09: if (n >= 6) begin en = 3; eb[1] = 0; eb[2] = 0; m_sec = {pk[2], pk[3], pk[4], pk[5]}; end
      8'h03: begin en = 7; eb[1] = 0; eb[2] = 0;
             eb[3] = m_sec[31:24]; eb[4] = m_sec[23:16]; eb[5] = m_sec[15:8]; eb[6] = m_sec[7:0]; end
      8'h13, 8'h14, 8'h19, 8'h21, 8'h0A, 8'h11: begin en = 2; eb[1] = 0; end
      default: en = 0;
    endcase
  endfunction

  task automatic expect_none(input string req);
    bit seen = 0;
    repeat (6) begin @(negedge clk); if (rsp_valid) seen = 1; end
    chk(!seen, req, "unexpected reply", seen, 0);
  endtask

  task automatic run_pkt(input int n, input string req, input bit rnd);
    model(n);
    send(n);
    if (en == 0) expect_none(req);
    else begin
      bit ok;
      get_rsp(rnd);
      ok = (rn == en);
      for (int i = 0; i < en && i < 8; i++) if (rb[i] != eb[i]) ok = 0;
      chk(ok, req, $sformatf("reply len/b0/blast cmd %0h", pk[1]),
          {rn[7:0], rb[0], rb[en > 0 ? en - 1 : 0]}, {en[7:0], eb[0], eb[en > 0 ? en - 1 : 0]});
      chk(hold_bad == 0, "R11", "reply not held or cmd accepted while busy", hold_bad, 0);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    m_sec = m_sec + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1904));
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !autopoll && !poll_req && !shut_req && !rst_req && cmd_ready, "R1", "reset outputs",
        {rsp_valid, autopoll, poll_req, shut_req, rst_req, cmd_ready}, 6'b000001);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 set time, R4 get time and ticks
    pk[0] = 1; pk[1] = 8'h09; pk[2] = 8'hDE; pk[3] = 8'hAD; pk[4] = 8'hBE; pk[5] = 8'hEF;
    run_pkt(6, "R3", 0);
    do_tick(); do_tick(); do_tick();
    pk[0] = 1; pk[1] = 8'h03; run_pkt(2, "R4", 1);
    chk({rb[3], rb[4], rb[5], rb[6]} == 32'hDEADBEF2, "R4", "time after 3 ticks", {rb[3], rb[4], rb[5], rb[6]}, 32'hDEADBEF2);

    // R5 acks
    pk[1] = 8'h13; run_pkt(2, "R5", 0);
    pk[1] = 8'h14; run_pkt(3, "R5", 1);
    pk[1] = 8'h19; run_pkt(2, "R5", 1);
    pk[1] = 8'h21; run_pkt(2, "R5", 0);
    pk[1] = 8'h03; run_pkt(2, "R5", 0);

    // R7 unknown
    pk[0] = 1; pk[1] = 8'h02; run_pkt(2, "R7", 0);
    pk[0] = 0; pk[1] = 8'h03; run_pkt(2, "R7", 0);
    pk[0] = 5; pk[1] = 8'h01; pk[2] = 1; run_pkt(3, "R7", 0);

    // R8 short packets
    pk[0] = 1; pk[1] = 8'h01; run_pkt(2, "R8", 0);
    chk(autopoll == 0, "R8", "short autopoll changed state", autopoll, 0);
    pk[1] = 8'h09; pk[2] = 1; pk[3] = 2; pk[4] = 3; run_pkt(5, "R8", 0);
    pk[0] = 1; run_pkt(1, "R8", 0);
    pk[1] = 8'h03; run_pkt(2, "R8", 0);
    chk({rb[3], rb[4], rb[5], rb[6]} == 32'hDEADBEF2, "R8", "short set-time altered clock",
        {rb[3], rb[4], rb[5], rb[6]}, 32'hDEADBEF2);

    // R2 + R9 autopoll
    begin
      int c, last, per, cnt;
      c = 0; cnt = 0;
      repeat (300) begin @(negedge clk); if (poll_req) cnt++; end
      chk(cnt == 0, "R9", "poll pulses while disabled", cnt, 0);
      pk[0] = 1; pk[1] = 8'h01; pk[2] = 8'h7F; run_pkt(3, "R2", 1);
      chk(autopoll == 1, "R2", "autopoll enable", autopoll, 1);
      last = -1; per = 0; cnt = 0;
      for (int t = 0; t < 320; t++) begin
        @(negedge clk);
        if (poll_req) begin
          cnt++;
          if (last >= 0) per = t - last;
          last = t;
        end
      end
      chk(per == 100, "R9", "poll period", per, 100);
      chk(cnt >= 3, "R9", "poll pulse count", cnt, 3);
      pk[2] = 8'h00; run_pkt(3, "R2", 0);
      chk(autopoll == 0, "R2", "autopoll disable", autopoll, 0);
      c = c + 0;
    end

    // R10 poll data
    @(negedge clk); poll_valid = 1; poll_data = 16'hABCD;
    while (!poll_ready) @(negedge clk);
    @(posedge clk); @(negedge clk); poll_valid = 0;
    get_rsp(1);
    chk(rn == 4 && rb[0] == 8'h00 && rb[1] == 8'h40 && rb[2] == 8'hAB && rb[3] == 8'hCD, "R10", "poll reply",
        {rn[7:0], rb[0], rb[1], rb[2], rb[3]}, {8'd4, 32'h0040ABCD});
    chk(hold_bad == 0, "R11", "poll reply hold", hold_bad, 0);

    // R6 power-down and reset
    pk[0] = 1; pk[1] = 8'h0A; send(2); get_rsp(1);
    chk(shut_req == 1 && rst_req == 0 && early_pulse == 0, "R6", "shutdown pulse",
        {shut_req, rst_req, early_pulse[0]}, 3'b100);
    @(negedge clk);
    chk(shut_req == 0, "R6", "shutdown one cycle", shut_req, 0);
    pk[1] = 8'h11; send(2); get_rsp(0);
    chk(rst_req == 1 && shut_req == 0 && early_pulse == 0, "R6", "reset pulse",
        {rst_req, shut_req, early_pulse[0]}, 3'b100);
    @(negedge clk);
    chk(rst_req == 0, "R6", "reset one cycle", rst_req, 0);

    // random mix: R2 R3 R4 R5 R7 R8
    for (int k = 0; k < 60; k++) begin
      logic [7:0] ops[9];
      int n;
      ops = '{8'h01, 8'h03, 8'h09, 8'h13, 8'h14, 8'h19, 8'h21, 8'h02, 8'h07};
      pk[0] = ($urandom % 6 == 0) ? 8'($urandom % 7) : 8'h01;
      pk[1] = ops[$urandom % 9];
      for (int i = 2; i < 8; i++) pk[i] = 8'($urandom);
      if (pk[1] == 8'h01 && ($urandom % 2)) pk[2] = 0;
      n = 1 + $urandom % 7;
      run_pkt(n, "R2/R3/R4/R5/R7/R8", 1);
      chk(autopoll == m_ap, "R2", "autopoll state random", autopoll, m_ap);
      if ($urandom % 4 == 0) do_tick();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule